// File: doc/BRIEF.md
# Multi-Context Time-Multiplexed Lookup Array

This block is a small logic array built from a few physical 3-input lookup elements. Each element is reused across a fixed number of contexts. Each element keeps a private store with one configuration word per context. A shared context counter reads that store, so on every cycle of a run each element applies a different truth table to a different choice of inputs.

Each element's output is caught in its own retiming register. Later contexts can read that register, either from the same element or from any other. A circuit whose logic has already been split into levels offline can therefore be evaluated one level per cycle on the same hardware.

Configuration is written while the array is idle. A start pulse then samples the primary inputs and clears the retiming registers. The array steps through every context and raises a one-cycle result strobe. The controller has three states:

- `ST_IDLE` waits for a start.
- `ST_RUN` evaluates one context per cycle.
- `ST_DONE` presents the result.

Its transitions are:

- IDLE→RUN on an accepted start.
- RUN→RUN while the context is not the last one.
- RUN→DONE after the last context.
- DONE→RUN on a start arriving in that cycle.
- DONE→IDLE otherwise.

Top module: `mctx_lut_array`

## Requirements
- R1: During and right after reset, `result_valid` and `busy` are 0 and `result` is all zeros.
- R2: A configuration write (`cfg_we` high) stores `cfg_data` into the word chosen by `cfg_addr`. Bits [3:2] of the address pick the element and bits [1:0] pick the context. The word layout is: truth table in [7:0], select 0 in [10:8], select 1 in [13:11], select 2 in [16:14], and the active flag in [17].
- R3: A configuration write presented while `busy` is high changes no stored word.
- R4: A start accepted in ST_IDLE or ST_DONE does four things: it clears all retiming registers, it sets the context to 0, it latches `pi`, and it makes `busy` read 1 in the next cycle.
- R5: Changes on `pi` after the accepting edge have no effect on the result of that run.
- R6: In each RUN cycle, every element uses its word for the current context. A select value s below 4 picks latched `pi[s]`; a value of 4 or more picks the retiming register of element s-4. The LUT output is bit {in2,in1,in0} of the truth table.
- R7: Every source an element reads is the value registered at the end of an earlier context. This includes the element's own register, so all elements of one context update together.
- R8: An element whose word for the current context has the active flag at 0 keeps its retiming register unchanged.
- R9: `result_valid` is high for exactly one cycle, the cycle after the last context is evaluated. That is 5 cycles after the accepting edge, and `result` then shows the retiming registers, element 0 in bit 0.
- R10: A start seen during ST_RUN is ignored and does not alter the run's timing or result.
- R11: A start seen in ST_DONE launches the next run at once, giving one result every 5 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | {element, context} of the word to write |
| cfg_data | input | 18 | Configuration word |
| start | input | 1 | Start a run |
| pi | input | 4 | Primary inputs, latched at start |
| busy | output | 1 | Run in progress or result being presented |
| result_valid | output | 1 | One-cycle result strobe |
| result | output | 4 | Retiming register values |

## Verification
A stuck or misordered context counter changes `result` in the very next run, and shifts the `result_valid` strobe away from its fifth cycle after start. A mis-decoded select or truth-table bit shows up in the first run whose input pattern reaches that table entry, which is why every primary-input pattern is swept. A retiming register that updates when it should hold, or that reads a same-context value, shows up at the end of that same run. A configuration store that accepts a write while busy only shows up on the following run with identical inputs, so that run is repeated on purpose.

// File: rtl/mctx_pkg.sv
package mctx_pkg;
    localparam int N_CTX    = 4;
    localparam int N_ELEM   = 4;
    localparam int N_PI     = 4;
    localparam int LUT_IN   = 3;
    localparam int TT_W     = 1 << LUT_IN;
    localparam int N_SRC    = N_PI + N_ELEM;
    localparam int SEL_W    = $clog2(N_SRC);
    localparam int CTX_W    = $clog2(N_CTX);
    localparam int ELEM_W   = $clog2(N_ELEM);
    localparam int ADDR_W   = ELEM_W + CTX_W;
    localparam int CFG_W    = 1 + LUT_IN * SEL_W + TT_W;
    localparam logic [CTX_W-1:0] CTX_LAST = CTX_W'(N_CTX - 1);

    typedef struct packed {
        logic             active;
        logic [SEL_W-1:0] sel2;
        logic [SEL_W-1:0] sel1;
        logic [SEL_W-1:0] sel0;
        logic [TT_W-1:0]  tt;
    } cfg_word_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } state_t;
endpackage

// File: rtl/mctx_ctrl.sv
module mctx_ctrl
    import mctx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             launch,
    output logic             eval_en,
    output logic             busy,
    output logic             result_valid,
    output logic [CTX_W-1:0] ctx
);
    state_t state_q, state_d;

    always_comb begin
        launch = start && (state_q == ST_IDLE || state_q == ST_DONE);
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (launch) state_d = ST_RUN;
            ST_RUN:  if (ctx == CTX_LAST) state_d = ST_DONE;
            ST_DONE: state_d = launch ? ST_RUN : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ctx     <= '0;
        end else begin
            state_q <= state_d;
            if (launch)
                ctx <= '0;
            else if (state_q == ST_RUN)
                ctx <= (ctx == CTX_LAST) ? '0 : ctx + CTX_W'(1);
        end
    end

    always_comb begin
        eval_en      = (state_q == ST_RUN);
        busy         = (state_q != ST_IDLE);
        result_valid = (state_q == ST_DONE);
    end

    a_r9_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);
    a_r9_valid_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> ($past(eval_en) && $past(ctx) == CTX_LAST));
    a_r4_launch_ctx0: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (eval_en && ctx == '0));
    a_r10_run_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_en && ctx != CTX_LAST) |=> (eval_en && ctx == CTX_W'($past(ctx) + 1)));
endmodule

// File: rtl/mctx_cfg_store.sv
module mctx_cfg_store
    import mctx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_sel,
    input  logic             busy,
    input  logic [CTX_W-1:0] wctx,
    input  cfg_word_t        wdata,
    input  logic [CTX_W-1:0] rctx,
    output cfg_word_t        rword
);
    cfg_word_t [N_CTX-1:0] mem;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mem <= '0;
        else if (we_sel && !busy)
            mem[wctx] <= wdata;
    end

    assign rword = mem[rctx];

    a_r3_locked_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (we_sel && busy) |=> $stable(mem));
endmodule

// File: rtl/mctx_elem.sv
module mctx_elem
    import mctx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             eval_en,
    input  cfg_word_t        cfg,
    input  logic [N_SRC-1:0] src,
    output logic             q
);
    logic [LUT_IN-1:0] idx;
    logic              lut_out;

    always_comb begin
        idx     = {src[cfg.sel2], src[cfg.sel1], src[cfg.sel0]};
        lut_out = cfg.tt[idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= 1'b0;
        else if (clear)
            q <= 1'b0;
        else if (eval_en && cfg.active)
            q <= lut_out;
    end

    a_r8_inactive_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_en && !cfg.active && !clear) |=> $stable(q));
    a_r4_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !q);
endmodule

// File: rtl/mctx_lut_array.sv
module mctx_lut_array
    import mctx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CFG_W-1:0]  cfg_data,
    input  logic              start,
    input  logic [N_PI-1:0]   pi,
    output logic              busy,
    output logic              result_valid,
    output logic [N_ELEM-1:0] result
);
    logic              launch;
    logic              eval_en;
    logic [CTX_W-1:0]  ctx;
    logic [N_PI-1:0]   pi_q;
    logic [N_ELEM-1:0] regs;
    logic [N_SRC-1:0]  src;

    mctx_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .launch       (launch),
        .eval_en      (eval_en),
        .busy         (busy),
        .result_valid (result_valid),
        .ctx          (ctx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pi_q <= '0;
        else if (launch)
            pi_q <= pi;
    end

    assign src = {regs, pi_q};

    for (genvar e = 0; e < N_ELEM; e++) begin : g_elem
        cfg_word_t word;
        logic      we_sel;

        assign we_sel = cfg_we && (cfg_addr[ADDR_W-1:CTX_W] == ELEM_W'(e));

        mctx_cfg_store u_store (
            .clk    (clk),
            .rst_n  (rst_n),
            .we_sel (we_sel),
            .busy   (busy),
            .wctx   (cfg_addr[CTX_W-1:0]),
            .wdata  (cfg_word_t'(cfg_data)),
            .rctx   (ctx),
            .rword  (word)
        );

        mctx_elem u_elem (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (launch),
            .eval_en (eval_en),
            .cfg     (word),
            .src     (src),
            .q       (regs[e])
        );
    end

    assign result = regs;

    a_r5_pi_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !launch |=> $stable(pi_q));
    a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!eval_en && !launch) |=> $stable(result));
endmodule

// File: tb/test_mctx_lut_array.sv
module test_mctx_lut_array;
    import mctx_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cfg_we;
    logic [ADDR_W-1:0] cfg_addr;
    logic [CFG_W-1:0]  cfg_data;
    logic              start;
    logic [N_PI-1:0]   pi;
    logic              busy;
    logic              result_valid;
    logic [N_ELEM-1:0] result;

    always #2 clk = ~clk;

    mctx_lut_array i_mctx_lut_array (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .start(start), .pi(pi), .busy(busy),
        .result_valid(result_valid), .result(result)
    );

    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [CFG_W-1:0]  cfg_m [N_ELEM][N_CTX];
    logic [N_ELEM-1:0] exp_q [$];
    int                cyc_q [$];
    string             tag_q [$];

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic logic [CFG_W-1:0] mk(input bit a, input int s2, input int s1,
                                            input int s0, input logic [7:0] tt);
        return {a, s2[2:0], s1[2:0], s0[2:0], tt};
    endfunction

    // Reference evaluation built from R4, R6, R7, R8
    function automatic logic [N_ELEM-1:0] model(input logic [N_PI-1:0] p);
        logic [N_ELEM-1:0] r, nr;
        logic [N_SRC-1:0]  s;
        logic [CFG_W-1:0]  w;
        logic [2:0]        ix;
        r = '0;
        for (int c = 0; c < N_CTX; c++) begin
            nr = r;
            s  = {r, p};
            for (int e = 0; e < N_ELEM; e++) begin
                w  = cfg_m[e][c];
                ix = {s[w[16:14]], s[w[13:11]], s[w[10:8]]};
                if (w[17]) nr[e] = w[ix];
            end
            r = nr;
        end
        return r;
    endfunction

    task automatic wcfg(input int e, input int c, input logic [CFG_W-1:0] w, input bit upd);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_addr = ADDR_W'(e * N_CTX + c);
        cfg_data = w;
        if (upd) cfg_m[e][c] = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic go(input logic [N_PI-1:0] p, input string tag);
        @(negedge clk);
        pi    = p;
        start = 1'b1;
        exp_q.push_back(model(p));
        cyc_q.push_back(cyc + N_CTX + 1);
        tag_q.push_back(tag);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R4 busy after start", busy, 1);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin : mon
        logic [N_ELEM-1:0] e;
        int                c;
        string             t;
        if (rst_n === 1'b1 && result_valid === 1'b1) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9/R10 unexpected result strobe", result, 0);
            end else begin
                e = exp_q.pop_front();
                c = cyc_q.pop_front();
                t = tag_q.pop_front();
                check(result == e, t, result, e);
                check(cyc == c, {t, " R9 strobe timing"}, cyc, c);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual 0 expected 1 (run completion)");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        cfg_we = 0; cfg_addr = '0; cfg_data = '0; start = 0; pi = '0; rst_n = 0;
        for (int e = 0; e < N_ELEM; e++)
            for (int c = 0; c < N_CTX; c++) cfg_m[e][c] = '0;
        repeat (3) @(negedge clk);
        check(result_valid == 0 && busy == 0, "R1 flags in reset", {result_valid, busy}, 0);
        check(result == 0, "R1 result in reset", result, 0);
        rst_n = 1;
        @(negedge clk);
        check(result_valid == 0 && busy == 0 && result == 0, "R1 after release",
              {result_valid, busy, result}, 0);

        // Levelized circuit: sum/carry, then combine, then parity, then feedback
        wcfg(0, 0, mk(1, 2, 1, 0, 8'h96), 1);
        wcfg(1, 0, mk(1, 2, 1, 0, 8'hE8), 1);
        wcfg(2, 0, mk(0, 0, 0, 0, 8'h00), 1);
        wcfg(3, 0, mk(0, 0, 0, 0, 8'h00), 1);
        wcfg(0, 1, mk(0, 0, 0, 0, 8'hFF), 1);
        wcfg(1, 1, mk(0, 0, 0, 0, 8'hFF), 1);
        wcfg(2, 1, mk(1, 3, 3, 4, 8'h88), 1);
        wcfg(3, 1, mk(1, 4, 4, 5, 8'hEE), 1);
        wcfg(0, 2, mk(1, 5, 7, 6, 8'h96), 1);
        wcfg(1, 2, mk(0, 0, 0, 0, 8'h00), 1);
        wcfg(2, 2, mk(0, 0, 0, 0, 8'h00), 1);
        wcfg(3, 2, mk(0, 0, 0, 0, 8'h00), 1);
        wcfg(0, 3, mk(0, 0, 0, 0, 8'h00), 1);
        wcfg(1, 3, mk(1, 5, 5, 5, 8'h01), 1);
        wcfg(2, 3, mk(0, 0, 0, 0, 8'hFF), 1);
        wcfg(3, 3, mk(1, 3, 3, 3, 8'h80), 1);
        for (int p = 0; p < 16; p++) begin
            go(4'(p), "R2/R6/R7 levelized sweep");
            repeat (N_CTX) @(negedge clk);
        end

        go(4'b0111, "R5 inputs changed mid-run");
        for (int k = 0; k < N_CTX; k++) begin
            @(negedge clk);
            pi = pi ^ 4'hF;
        end

        go(4'b1010, "R10 start during run");
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        repeat (N_CTX - 2) @(negedge clk);

        go(4'b1101, "R3 run with locked write");
        wcfg(0, 2, mk(1, 0, 0, 0, 8'h00), 0);
        repeat (N_CTX - 2) @(negedge clk);
        go(4'b1101, "R3 rerun after locked write");
        repeat (N_CTX) @(negedge clk);

        go(4'b0011, "R11 back-to-back first");
        repeat (N_CTX - 1) @(negedge clk);
        go(4'b1100, "R11 back-to-back second");
        repeat (N_CTX - 1) @(negedge clk);
        go(4'b1001, "R11 back-to-back third");
        repeat (N_CTX) @(negedge clk);

        lf = 32'hACE1_5A17;
        for (int e = 0; e < N_ELEM; e++)
            for (int c = 0; c < N_CTX; c++) begin
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                lf = lf * 32'd1103515245 + 32'd12345;
                wcfg(e, c, lf[CFG_W-1:0], 1);
            end
        for (int k = 0; k < 8; k++) begin
            go(4'(k * 7 + 3), "R6/R7 scrambled configuration");
            repeat (N_CTX) @(negedge clk);
        end

        go(4'hF, "R8 preload before inactive run");
        repeat (N_CTX) @(negedge clk);
        for (int e = 0; e < N_ELEM; e++)
            for (int c = 0; c < N_CTX; c++)
                wcfg(e, c, cfg_m[e][c] & ~(CFG_W'(1) << 17), 1);
        go(4'hF, "R8/R4 all inactive gives cleared registers");
        repeat (N_CTX) @(negedge clk);

        // Holding across contexts and own-register feedback
        for (int e = 0; e < N_ELEM; e++)
            for (int c = 0; c < N_CTX; c++) wcfg(e, c, mk(0, 0, 0, 0, 8'h00), 1);
        for (int c = 0; c < N_CTX; c++) wcfg(0, c, mk(1, 4, 4, 4, 8'h55), 1);
        wcfg(1, 1, mk(1, 4, 4, 4, 8'hAA), 1);
        wcfg(2, 0, mk(1, 2, 2, 2, 8'hAA), 1);
        go(4'b0100, "R7 own feedback four toggles");
        repeat (N_CTX) @(negedge clk);
        wcfg(0, 3, mk(0, 4, 4, 4, 8'h55), 1);
        go(4'b0000, "R7/R8 three toggles then hold");
        repeat (N_CTX) @(negedge clk);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R9 missing result strobes", exp_q.size(), 0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule